// File: doc/BRIEF.md
# Overlapped Radix-2 SRT Significand Divider

This block divides two normalized fixed-point significands, each a fraction in [0.5, 1). It uses a digit-recurrence method with the signed digits -1, 0 and +1, and it produces two quotient digits per clock. The partial remainder is held as separate sum and carry vectors, so every step costs one 3:2 carry-save addition and no full-width carry chain. Each digit is chosen from a 4-bit estimate built from the top bits of those two vectors.

To fit two digits into one clock, the second digit is chosen speculatively. Three narrow selectors each assume one value of the first digit and compute the digit that would follow it. When the first digit resolves, a mux picks one of the three results. After the last iteration, one conversion cycle does three things: it forms the quotient as the difference of the positive-digit and negative-digit vectors, resolves the remainder with a carry-propagate add, and lowers the quotient by one if that remainder is negative.

Operands enter through a valid/ready handshake, and the ready signal is high only while the unit is idle. A request offered while the unit is busy is not accepted and has no effect. The result is a single-cycle valid pulse with no back-pressure, so the consumer must take it in that cycle.

Top module: `srt2_overlap_div`

## Requirements
- R1: While reset is applied and after it is released, in_ready is 1 and out_valid is 0.
- R2: An operand pair is accepted on a rising edge where in_valid and in_ready are both 1. in_ready is 0 from the cycle after acceptance until the cycle in which the result is presented. in_valid raised while in_ready is 0 is ignored: it starts no operation, produces no result and does not change the result in flight.
- R3: out_valid is 1 for exactly one cycle, the 28th cycle after the accepting edge (iterations plus one conversion cycle). Each accepted request gives exactly one result, and no out_ready input exists.
- R4: An operand with integer value V represents V·2^-53, with bit 52 set. out_quotient equals floor(dividend·2^53 / divisor) as a 54-bit unsigned integer, meaning the quotient is scaled by 2^-53.
- R5: out_inexact is 1 when dividend·2^53 is not a multiple of divisor, and 0 otherwise.
- R6: On every iteration cycle, the carry-save partial remainder and the intermediate remainder after the first digit of the cycle both lie within [-D, +D].
- R7: The second digit of each cycle, taken from the speculative selectors, equals the digit that a direct selection would choose from the first stage's full result.
- R8: When the final carry-save remainder is negative, including the case where it equals -D, the quotient is lowered by one. This yields exact quotients for equal operands, such as 0.5/0.5 = 2^53.
- R9: Extreme operands give the floor quotient of R4: divisor 0.5, divisor 1 - 2^-53, and dividend 1 - 2^-53.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit idle; an offered pair is taken at the next edge |
| in_dividend | input | 53 | Dividend significand, bit 52 set |
| in_divisor | input | 53 | Divisor significand, bit 52 set |
| out_valid | output | 1 | Single-cycle result strobe |
| out_quotient | output | 54 | Truncated quotient scaled by 2^-53 |
| out_inexact | output | 1 | Remainder is nonzero |

## Verification
Some properties are checked on every iteration cycle by the bound checker: the remainder bound, both before and between the two digits of a cycle; agreement between the speculative second digit and a direct selection; the single-cycle result pulse at the fixed latency; and in_ready dropping after each acceptance. Other behaviour can only be shown by the bench scenarios against an integer long-division model. This covers the numerical result itself: the exact truncated quotient, the inexact flag, the negative-remainder correction on equal operands, and the extreme divisors. The scenarios also confirm that requests offered while busy leave the in-flight result unchanged.

// File: rtl/srt2_pkg.sv
package srt2_pkg;

  // Signed quotient digit: pos=1 means +1, neg=1 means -1, both 0 means 0.
  typedef struct packed {
    logic pos;
    logic neg;
  } sdigit_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } srt2_state_t;

  // Estimate width: three integer bits plus one fractional bit (units of 1/2).
  localparam int EST_W = 4;

  // Digit selection on the truncated carry-save estimate of the doubled remainder.
  function automatic sdigit_t pick_digit(input logic [EST_W-1:0] s_hi,
                                         input logic [EST_W-1:0] c_hi);
    logic [EST_W-1:0] est;
    sdigit_t          d;
    est = s_hi + c_hi;
    if (!est[EST_W-1]) begin
      d.pos = 1'b1;
      d.neg = 1'b0;
    end else if (est == '1) begin
      d.pos = 1'b0;
      d.neg = 1'b0;
    end else begin
      d.pos = 1'b0;
      d.neg = 1'b1;
    end
    return d;
  endfunction

endpackage

// File: rtl/srt2_csa.sv
// One full-width recurrence step: doubles the carry-save remainder and adds -q*D.
module srt2_csa
  import srt2_pkg::*;
#(
  parameter int W = 57
) (
  input  logic [W-2:0] s_in,
  input  logic [W-2:0] c_in,
  input  sdigit_t      d,
  input  logic [W-1:0] dmul,
  output logic [W-1:0] s_out,
  output logic [W-1:0] c_out
);
  logic [W-1:0] s_sh, c_sh, m;
  logic [W-2:0] maj;

  always_comb begin
    s_sh  = {s_in, 1'b0};
    c_sh  = {c_in, 1'b0};
    // Only +D is distributed; -D is the inverse plus a carry-in of one.
    if (d.pos)      m = ~dmul;
    else if (d.neg) m = dmul;
    else            m = '0;
    s_out = s_sh ^ c_sh ^ m;
    maj   = (s_sh[W-2:0] & c_sh[W-2:0]) | (s_sh[W-2:0] & m[W-2:0]) | (c_sh[W-2:0] & m[W-2:0]);
    c_out = {maj, d.pos};
  end
endmodule

// File: rtl/srt2_spec_sel.sv
// Narrow speculative selector: top slice of a CSA step for one assumed first digit,
// followed by selection of the digit that would come next.
module srt2_spec_sel
  import srt2_pkg::*;
#(
  parameter int SW = EST_W + 1
) (
  input  logic [SW-1:0] s_sl,
  input  logic [SW-1:0] c_sl,
  input  logic [SW-1:0] m_sl,
  output sdigit_t       q
);
  logic [SW-2:0] sum_hi, car_hi;

  always_comb begin
    sum_hi = s_sl[SW-1:1] ^ c_sl[SW-1:1] ^ m_sl[SW-1:1];
    car_hi = (s_sl[SW-2:0] & c_sl[SW-2:0]) | (s_sl[SW-2:0] & m_sl[SW-2:0]) |
             (c_sl[SW-2:0] & m_sl[SW-2:0]);
    q      = pick_digit(sum_hi, car_hi);
  end
endmodule

// File: rtl/srt2_qconv.sv
// Final conversion: signed-digit vectors to binary, remainder sign and zero test.
module srt2_qconv #(
  parameter int W = 57,
  parameter int K = 54
) (
  input  logic [W-1:0] s_fin,
  input  logic [W-1:0] c_fin,
  input  logic [W-1:0] dext,
  input  logic [K-1:0] qp,
  input  logic [K-1:0] qn,
  output logic [K-1:0] quo,
  output logic         inexact
);
  logic [W-1:0] wsum, rem;
  logic         neg;

  always_comb begin
    wsum    = s_fin + c_fin;
    neg     = wsum[W-1];
    rem     = neg ? (wsum + dext) : wsum;
    quo     = qp - qn - {{(K-1){1'b0}}, neg};
    inexact = |rem;
  end
endmodule

// File: rtl/srt2_overlap_div.sv
module srt2_overlap_div
  import srt2_pkg::*;
#(
  parameter int N = 53,
  localparam int K = 2 * ((N + 2) / 2)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_dividend,
  input  logic [N-1:0] in_divisor,
  output logic         out_valid,
  output logic [K-1:0] out_quotient,
  output logic         out_inexact
);
  localparam int W     = N + 4;        // 3 integer bits, N+1 fraction bits
  localparam int ITERS = K / 2;
  localparam int CNT_W = $clog2(ITERS);
  localparam int SW    = EST_W + 1;
  localparam int NCAND = 3;            // candidates for the first digit: +1, 0, -1

  srt2_state_t      state;
  logic [CNT_W-1:0] iter_cnt;
  logic [W-1:0]     s_r, c_r, s1, c1, s2n, c2n, dext;
  logic [N-1:0]     d_r;
  logic [K-1:0]     qp_r, qn_r, quo_w;
  logic             inexact_w;
  sdigit_t          q1, q2;
  sdigit_t          spec_q [NCAND];

  assign dext     = {3'b000, d_r, 1'b0};
  assign in_ready = (state == ST_IDLE);

  // Primary selection on the current remainder.
  assign q1 = pick_digit(s_r[W-2:W-1-EST_W], c_r[W-2:W-1-EST_W]);

  // Speculative selections, one per possible first digit.
  for (genvar g = 0; g < NCAND; g++) begin : g_spec
    logic [SW-1:0] m_sl;
    if (g == 0) begin : g_plus
      assign m_sl = ~dext[W-2:W-1-SW];
    end else if (g == 1) begin : g_zero
      assign m_sl = '0;
    end else begin : g_minus
      assign m_sl = dext[W-2:W-1-SW];
    end
    srt2_spec_sel #(.SW(SW)) u_sel (
      .s_sl (s_r[W-3:W-2-SW]),
      .c_sl (c_r[W-3:W-2-SW]),
      .m_sl (m_sl),
      .q    (spec_q[g])
    );
  end

  always_comb begin
    if (q1.pos)      q2 = spec_q[0];
    else if (q1.neg) q2 = spec_q[2];
    else             q2 = spec_q[1];
  end

  srt2_csa #(.W(W)) u_stage1 (
    .s_in (s_r[W-2:0]), .c_in (c_r[W-2:0]), .d (q1), .dmul (dext),
    .s_out(s1),         .c_out(c1)
  );

  srt2_csa #(.W(W)) u_stage2 (
    .s_in (s1[W-2:0]),  .c_in (c1[W-2:0]),  .d (q2), .dmul (dext),
    .s_out(s2n),        .c_out(c2n)
  );

  srt2_qconv #(.W(W), .K(K)) u_conv (
    .s_fin(s_r), .c_fin(c_r), .dext(dext), .qp(qp_r), .qn(qn_r),
    .quo  (quo_w), .inexact(inexact_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      iter_cnt     <= '0;
      s_r          <= '0;
      c_r          <= '0;
      d_r          <= '0;
      qp_r         <= '0;
      qn_r         <= '0;
      out_valid    <= 1'b0;
      out_quotient <= '0;
      out_inexact  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            // Operand injection: remainder starts at dividend/2, carry vector cleared.
            s_r      <= {4'b0000, in_dividend};
            c_r      <= '0;
            d_r      <= in_divisor;
            qp_r     <= '0;
            qn_r     <= '0;
            iter_cnt <= '0;
            state    <= ST_RUN;
          end
        end
        ST_RUN: begin
          s_r      <= s2n;
          c_r      <= c2n;
          qp_r     <= {qp_r[K-3:0], q1.pos, q2.pos};
          qn_r     <= {qn_r[K-3:0], q1.neg, q2.neg};
          iter_cnt <= iter_cnt + 1'b1;
          if (iter_cnt == CNT_W'(ITERS - 1)) state <= ST_FIN;
        end
        ST_FIN: begin
          out_quotient <= quo_w;
          out_inexact  <= inexact_w;
          out_valid    <= 1'b1;
          state        <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srt2_overlap_div_chk.sv
module srt2_overlap_div_chk
  import srt2_pkg::*;
#(
  parameter int N = 53
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input srt2_state_t   state,
  input logic [N+3:0]  s_r,
  input logic [N+3:0]  c_r,
  input logic [N+3:0]  s1,
  input logic [N+3:0]  c1,
  input logic [N+3:0]  dext,
  input sdigit_t       q2
);
  localparam int W     = N + 4;
  localparam int ITERS = (N + 2) / 2;
  localparam int LAT_W = $clog2(ITERS + 2) + 1;

  logic signed [W-1:0] rem_now, rem_mid, dpos;
  logic                now_ok, mid_ok;
  sdigit_t             q2_direct;
  logic [LAT_W-1:0]    lat;
  logic                pend;

  always_comb begin
    rem_now   = signed'(s_r + c_r);
    rem_mid   = signed'(s1 + c1);
    dpos      = signed'(dext);
    now_ok    = (rem_now <= dpos) && (rem_now >= -dpos);
    mid_ok    = (rem_mid <= dpos) && (rem_mid >= -dpos);
    q2_direct = pick_digit(s1[W-2:W-1-EST_W], c1[W-2:W-1-EST_W]);
  end

  // Cycles since the last accepted request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat  <= '0;
      pend <= 1'b0;
    end else if (in_valid && in_ready) begin
      lat  <= '0;
      pend <= 1'b1;
    end else begin
      if (out_valid) pend <= 1'b0;
      if (pend)      lat  <= lat + 1'b1;
    end
  end

  assert_rem_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> now_ok);

  assert_mid_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> mid_ok);

  assert_spec_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (q2 == q2_direct));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_fixed_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pend && (lat == LAT_W'(ITERS + 1))));
endmodule

bind srt2_overlap_div srt2_overlap_div_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .state    (state),
  .s_r      (s_r),
  .c_r      (c_r),
  .s1       (s1),
  .c1       (c1),
  .dext     (dext),
  .q2       (q2)
);

// File: tb/srt2_overlap_div_tb_top.sv
module srt2_overlap_div_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 53;
  localparam int K   = 2 * ((N + 2) / 2);
  localparam int LAT = (N + 2) / 2 + 1;

  typedef struct {
    logic [K-1:0] quo;
    logic         inexact;
    int           acc;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [N-1:0] in_dividend = '0;
  logic [N-1:0] in_divisor = '0;
  logic         in_ready, out_valid, out_inexact;
  logic [K-1:0] out_quotient;

  int   checks = 0, fails = 0, cyc = 0, results = 0, sent = 0;
  bit   finished = 1'b0;
  exp_t exp_q[$];

  srt2_overlap_div dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor),
    .out_valid(out_valid), .out_quotient(out_quotient), .out_inexact(out_inexact)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what,
                       input logic [K-1:0] act, input logic [K-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [N-1:0] x, input logic [N-1:0] d);
    logic [N+K-2:0] num, den, q, r;
    exp_t e;
    num       = {x, {(K-1){1'b0}}};
    den       = {{(K-1){1'b0}}, d};
    q         = num / den;
    r         = num % den;
    e.quo     = q[K-1:0];
    e.inexact = (r != 0);
    e.acc     = 0;
    e.tag     = "";
    return e;
  endfunction

  // Driver: offers one pair, records the expected result, optionally pokes while busy.
  task automatic send(input logic [N-1:0] x, input logic [N-1:0] d,
                      input string tag, input int pokes);
    exp_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid    = 1'b1;
    in_dividend = x;
    in_divisor  = d;
    @(negedge clk);
    e     = model(x, d);
    e.acc = cyc;
    e.tag = tag;
    exp_q.push_back(e);
    sent++;
    in_valid = 1'b0;
    for (int i = 0; i < pokes; i++) begin
      in_valid    = 1'b1;
      in_dividend = ~x | {1'b1, {(N-1){1'b0}}};
      in_divisor  = {1'b1, ~d[N-2:0]};
      check(in_ready == 1'b0, "R2 in_ready while busy", K'(in_ready), '0);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        results++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 result without request", '1, '0);
        end else begin
          e = exp_q.pop_front();
          check(out_quotient == e.quo, $sformatf("R4 quotient [%s]", e.tag), out_quotient, e.quo);
          check(out_inexact == e.inexact, $sformatf("R5 inexact [%s]", e.tag),
                K'(out_inexact), K'(e.inexact));
          check((cyc - e.acc) == LAT, $sformatf("R3 latency [%s]", e.tag),
                K'(cyc - e.acc), K'(LAT));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R3 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] half, maxv, xr, dr;
    logic [31:0]  a, b, c2, d2;
    half = {1'b1, {(N-1){1'b0}}};
    maxv = '1;

    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", K'(out_valid), '0);
    check(in_ready == 1'b1, "R1 in_ready in reset", K'(in_ready), K'(1));
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", K'(out_valid), '0);
    check(in_ready == 1'b1, "R1 in_ready after reset", K'(in_ready), K'(1));

    send(half, half, "R8 equal halves", 8);
    send(maxv, maxv, "R8 R9 equal max", 0);
    send(maxv, half, "R9 divisor half dividend max", 3);
    send(half, maxv, "R9 divisor max dividend half", 0);
    send({2'b11, {(N-2){1'b0}}}, half, "R4 exact 1.5", 0);
    send(half, {2'b11, {(N-2){1'b0}}}, "R5 two thirds", 0);
    a = $urandom(); b = $urandom();
    xr = {1'b1, a[19:0], b};
    send(xr, xr, "R8 equal random", 0);

    for (int i = 0; i < 40; i++) begin
      a = $urandom(); b = $urandom(); c2 = $urandom(); d2 = $urandom();
      xr = {1'b1, a[19:0], b};
      dr = {1'b1, c2[19:0], d2};
      send(xr, dr, "R4 random", (i % 5 == 0) ? 6 : 0);
    end

    while (exp_q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    check(results == sent, "R2 one result per accepted request", K'(results), K'(sent));
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule